// File: doc/BRIEF.md
# Time-of-Day Alarm and Interrupt Flag Unit

This block sits beside a real-time clock's time counters. On every cycle in which the counters signal that an update has finished, it compares the current seconds, minutes and hours against three programmable alarm bytes. When all three fields match, it records an alarm event. An alarm byte whose two top bits are both set matches any time value, so a single field can be left out of the comparison.

The block gathers three kinds of event into one flag register: the alarm, the periodic tick and the end of an update. Each event has its own enable bit in a control register. A summary bit in the flag register, and the interrupt output, go high while any flag is set together with its enable. Software services the interrupt by reading the flag register. That read returns the flags and clears them.

Access uses a small register port: a 4-bit index, a write strobe, a read strobe and a combinational read bus. The time counters, the tick generator and the calendar fields above hours are outside the block.

Top module: `tod_alarm_irq`

## Requirements
- R1: After reset, the alarm bytes (indices 1, 3, 5), the control register (index 11) and the flag register (index 12) read 0x00, and irq_o is low.
- R2: A write to index 1, 3 or 5 stores the seconds, minutes or hours alarm byte, and a read of that index returns it. A write to a time index (0, 2, 4) leaves every alarm byte unchanged.
- R3: When upd_done_i is high and all three time fields equal their alarm bytes, flag bit 5 (alarm) is set from the next cycle on.
- R4: An alarm byte with bits 7 and 6 both set matches any time value. A byte with only bit 7 set must match exactly.
- R5: Flag bit 5 is never set in a cycle after upd_done_i was low, and it is not set when any field mismatches.
- R6: A tick_i pulse sets flag bit 6 (periodic). An upd_done_i pulse sets flag bit 4 (update ended). Each flag is set from the next cycle on.
- R7: Control index 11 holds the periodic enable in bit 6, the alarm enable in bit 5 and the update-ended enable in bit 4. Its other bits read 0.
- R8: Flags are set whatever their enables are. Flag bit 7 and irq_o are high exactly when some flag bit among 6..4 is set and its matching control bit is set.
- R9: A read of index 12 returns the current flags in that cycle and clears bits 7..4 from the next cycle on.
- R10: An event that arrives in the same cycle as a read of index 12 leaves its flag set after the clear.
- R11: Index 12 is read-only. A write to it changes neither the flags nor irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_i | input | 8 | Current seconds value |
| min_i | input | 8 | Current minutes value |
| hour_i | input | 8 | Current hours value |
| upd_done_i | input | 1 | One-cycle strobe: the time update has finished |
| tick_i | input | 1 | One-cycle periodic tick |
| addr_i | input | 4 | Register index |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe; a read of index 12 clears the flags |
| rdata_o | output | 8 | Read data of the indexed register (combinational) |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The alarm comparison is tried with an exact three-field match, with a single mismatching seconds field, and with a matching time that has no update strobe. Together these separate a strobe-gated compare from a free-running one. Wildcard bytes 0xC0 and 0x80 are tried against a non-matching time; this shows whether both top bits are required. Enables are set one at a time against single events, so a summary that ignores the enables or pairs them with the wrong flag is exposed. A tick placed in the same cycle as a flag read checks that the clear does not swallow a new event.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 4;
  localparam int unsigned NFIELD = 3;  // seconds, minutes, hours
  localparam int unsigned NEVT = 3;    // [2]=periodic [1]=alarm [0]=update-ended

  localparam logic [AW-1:0] IDX_CTRL = 4'd11;
  localparam logic [AW-1:0] IDX_FLAG = 4'd12;

  // lowest bit of the event group inside control and flag registers
  localparam int unsigned EVT_LSB = 4;
  localparam int unsigned SUM_BIT = 7;

  // alarm byte for field f sits at index 2f+1
  function automatic logic [AW-1:0] alarm_idx(input int unsigned f);
    return AW'(2 * f + 1);
  endfunction
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [NFIELD-1:0][DW-1:0]    alarm_o,
  output logic [NEVT-1:0]              en_o
);
  for (genvar f = 0; f < NFIELD; f++) begin : g_alarm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               alarm_o[f] <= '0;
      else if (wr_i && addr_i == alarm_idx(f))   alarm_o[f] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         en_o <= '0;
    else if (wr_i && addr_i == IDX_CTRL) en_o <= wdata_i[EVT_LSB +: NEVT];
  end
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NFIELD-1:0][DW-1:0] time_i,
  input  logic [NFIELD-1:0][DW-1:0] alarm_i,
  output logic                      match_o
);
  logic [NFIELD-1:0] hit;

  for (genvar f = 0; f < NFIELD; f++) begin : g_cmp
    assign hit[f] = (&alarm_i[f][DW-1:DW-2]) || (alarm_i[f] == time_i[f]);
  end

  assign match_o = &hit;

  assert_wild_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&alarm_i[0][DW-1:DW-2] && &alarm_i[1][DW-1:DW-2] && &alarm_i[2][DW-1:DW-2]) |-> match_o);
  assert_exact_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_i == alarm_i) |-> match_o);
endmodule

// File: rtl/tod_irq_flags.sv
module tod_irq_flags
  import tod_alarm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEVT-1:0] evt_i,
  input  logic [NEVT-1:0] en_i,
  input  logic            rd_clr_i,
  output logic [NEVT-1:0] flags_o,
  output logic            sum_o
);
  logic [NEVT-1:0] flags_q;

  // clear-on-read first, then fresh events, so none is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (rd_clr_i ? '0 : flags_q) | evt_i;
  end

  assign flags_o = flags_q;
  assign sum_o   = |(flags_q & en_i);

  assert_rd_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && evt_i == '0) |=> flags_q == '0);
  assert_evt_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[2] |=> flags_q[2]);
  assert_no_en_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !sum_o);
  assert_alarm_needs_upd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[1]) |-> $past(evt_i[0]));
endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq
  import tod_alarm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] sec_i,
  input  logic [DW-1:0] min_i,
  input  logic [DW-1:0] hour_i,
  input  logic          upd_done_i,
  input  logic          tick_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [NFIELD-1:0][DW-1:0] alarm, tod;
  logic [NEVT-1:0]           en, flags, evt;
  logic                      match, sum, rd_flag;

  assign tod     = {hour_i, min_i, sec_i};
  assign rd_flag = rd_i && addr_i == IDX_FLAG;
  assign evt     = {tick_i, upd_done_i && match, upd_done_i};

  tod_alarm_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .alarm_o(alarm), .en_o(en)
  );

  tod_alarm_match u_match (
    .clk_i, .rst_ni, .time_i(tod), .alarm_i(alarm), .match_o(match)
  );

  tod_irq_flags u_flags (
    .clk_i, .rst_ni, .evt_i(evt), .en_i(en), .rd_clr_i(rd_flag),
    .flags_o(flags), .sum_o(sum)
  );

  always_comb begin
    rdata_o = '0;
    for (int f = 0; f < NFIELD; f++)
      if (addr_i == alarm_idx(f)) rdata_o = alarm[f];
    if (addr_i == IDX_CTRL) rdata_o[EVT_LSB +: NEVT] = en;
    if (addr_i == IDX_FLAG) begin
      rdata_o[EVT_LSB +: NEVT] = flags;
      rdata_o[SUM_BIT]         = sum;
    end
  end

  assign irq_o = sum;

  assert_flag_ro_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == IDX_FLAG && !rd_i && !tick_i && !upd_done_i) |=> $stable(flags));
  assert_irq_sum_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IDX_FLAG) |-> (rdata_o[SUM_BIT] == irq_o));
endmodule

// File: tb/sim_tod_alarm_irq.sv
module sim_tod_alarm_irq;
  logic       clk = 0, rst_ni = 0;
  logic [7:0] sec_i = 0, min_i = 0, hour_i = 0, wdata_i = 0;
  logic       upd_done_i = 0, tick_i = 0, wr_i = 0, rd_i = 0;
  logic [3:0] addr_i = 0;
  logic [7:0] rdata_o;
  logic       irq_o;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #4 clk = ~clk;

  tod_alarm_irq u0 (.*, .clk_i(clk));

  // monitor: compare each read against the queued expectation
  always @(negedge clk) begin
    #1;
    if (rd_i && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata_o !== e) begin
        errors++;
        $display("FAIL %s addr=%0d got=%02h exp=%02h", t, addr_i, rdata_o, e);
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr_i = a; rd_i = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_i = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1;
    @(negedge clk);
    wr_i = 0;
  endtask

  task automatic upd();
    @(negedge clk); upd_done_i = 1;
    @(negedge clk); upd_done_i = 0;
  endtask

  task automatic tick();
    @(negedge clk); tick_i = 1;
    @(negedge clk); tick_i = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk); #1;
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s irq got=%b exp=%b", t, irq_o, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    rd(1, 8'h00, "R1"); rd(3, 8'h00, "R1"); rd(5, 8'h00, "R1");
    rd(11, 8'h00, "R1"); rd(12, 8'h00, "R1"); chk_irq(0, "R1");
    // R2 alarm bytes
    wr(1, 8'h30); wr(3, 8'h15); wr(5, 8'h08);
    rd(1, 8'h30, "R2"); rd(3, 8'h15, "R2"); rd(5, 8'h08, "R2");
    wr(0, 8'h55); wr(2, 8'h66); wr(4, 8'h77);
    rd(1, 8'h30, "R2"); rd(3, 8'h15, "R2"); rd(5, 8'h08, "R2");
    // R7 control bits
    wr(11, 8'hFF); rd(11, 8'h70, "R7");
    wr(11, 8'h00); rd(11, 8'h00, "R7");
    // R3 exact match, R8 flags set without enable
    sec_i = 8'h30; min_i = 8'h15; hour_i = 8'h08;
    upd();
    rd(12, 8'h30, "R3"); chk_irq(0, "R8");
    rd(12, 8'h00, "R9");
    // R5 match without strobe, then strobe with mismatch
    repeat (4) @(negedge clk);
    rd(12, 8'h00, "R5");
    sec_i = 8'h31; upd();
    rd(12, 8'h10, "R5");
    // R4 wildcard
    wr(1, 8'hC0); sec_i = 8'h47; upd();
    rd(12, 8'h30, "R4");
    wr(1, 8'h80); upd();
    rd(12, 8'h10, "R4");
    // R6 periodic
    tick(); rd(12, 8'h40, "R6");
    // R8 enable pairing
    wr(11, 8'h40); tick(); chk_irq(1, "R8");
    rd(12, 8'hC0, "R8"); chk_irq(0, "R9");
    wr(11, 8'h20); tick(); chk_irq(0, "R8");
    rd(12, 8'h40, "R8");
    wr(11, 8'h10); upd(); chk_irq(1, "R8");
    rd(12, 8'h90, "R6");
    // R10 event during read
    @(negedge clk);
    addr_i = 12; rd_i = 1; tick_i = 1;
    exp_q.push_back(8'h00); tag_q.push_back("R10");
    @(negedge clk);
    rd_i = 0; tick_i = 0;
    rd(12, 8'h40, "R10");
    // R11 write to flag register ignored
    wr(11, 8'h70);
    wr(12, 8'hFF); rd(12, 8'h00, "R11"); chk_irq(0, "R11");
    tick(); wr(12, 8'h00); chk_irq(1, "R11");
    rd(12, 8'hC0, "R11");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule